// File: doc/BRIEF.md
# Vector Float-to-Half Packing Converter

This block takes a vector of IEEE-754 single-precision numbers and turns each element into a half-precision number. It then packs the 16-bit results two to a 32-bit word, so the element count stays the same and the vector occupies half the width. A two-element vector becomes one packed word. A four-element vector becomes two packed words. One-element and three-element vectors cannot be packed in pairs. They are rejected with an illegal-size flag and produce no result.

Each element is converted on its own. Sign is kept. Infinity and NaN map to fixed codes, and a NaN payload is dropped. Finite magnitudes that exceed the half range saturate to infinity. All other finite values, including those that land in the half-precision denormal range, are rounded to nearest with ties to even. Single-precision denormal inputs flush to signed zero.

There is one register stage between the input and the output. The reset input is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `vec_f2h_pack`

## Requirements
- R1: Bit 15 of every half result equals bit 31 of its single-precision input, for every class of input including zero, NaN and flushed values.
- R2: An input with exponent field 0xFF and mantissa zero gives magnitude 0x7C00. With a non-zero mantissa it gives magnitude 0x7E00, whatever the payload.
- R3: A finite input with a biased exponent of 143 or more (magnitude at least 65536) gives magnitude 0x7C00.
- R4: A finite input with a biased exponent from 113 to 142 gives half exponent (e-112) and mantissa bits 22:13, rounded to nearest-even using bit 12 and the bits below it. A carry out of rounding raises the exponent, so 65520.0 gives 0x7C00.
- R5: A finite input with a biased exponent from 101 to 112 gives a half denormal, rounded to nearest-even, and a rounding carry may produce 0x0400. A biased exponent from 0 to 100 gives magnitude zero, and this covers single-precision denormals.
- R6: Size codes are 0 = single, 1 = pair, 2 = triple, 3 = quad. For a pair input, out_data[15:0] holds element 0, out_data[31:16] holds element 1, out_data[63:32] is zero, and out_size is 0.
- R7: For a quad input (elements at in_data[32k+31:32k]), word 0 packs element 0 low and element 1 high, out_data[63:32] packs element 2 low and element 3 high, and out_size is 1.
- R8: An input marked valid with size 0 or 2 raises out_illegal for one cycle and leaves out_valid low.
- R9: out_valid and out_illegal respond exactly one clock after the accepted input cycle. A cycle with in_valid low produces neither flag one clock later.
- R10: While rst_n is low, out_valid and out_illegal are low. Asserting rst_n clears them without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| in_valid | input | 1 | Input vector present this cycle |
| in_size | input | 2 | Input element count code (0 single, 1 pair, 2 triple, 3 quad) |
| in_data | input | 128 | Four single-precision elements, element k at bits 32k+31:32k |
| out_valid | output | 1 | Packed result present |
| out_illegal | output | 1 | Previous input had an unsupported size |
| out_size | output | 2 | Output element count code (0 single, 1 pair) |
| out_data | output | 64 | Packed half results, word 0 in bits 31:0 |

## Verification
The properties take in_data and in_size as meaningful only in a cycle where in_valid is high. They compare each output with the input of the previous cycle through $past. Because the reset is released through a synchroniser, they also rely on in_valid staying low for the first cycles after rst_n rises, since an input arriving in that window would be dropped. The stimulus keeps within these conditions: it drives inputs only at falling edges, holds in_valid low through every reset and for several cycles after release, and lowers in_valid between vectors.

// File: rtl/f2h_pkg.sv
package f2h_pkg;

  typedef enum logic [1:0] {
    VSZ_SINGLE = 2'd0,
    VSZ_PAIR   = 2'd1,
    VSZ_TRIPLE = 2'd2,
    VSZ_QUAD   = 2'd3
  } vsize_e;

  localparam int SP_W = 32;
  localparam int HP_W = 16;

  localparam logic [HP_W-2:0] HP_INF_MAG  = 15'h7C00;
  localparam logic [HP_W-2:0] HP_QNAN_MAG = 15'h7E00;

  // exponent thresholds of the single-precision input
  localparam logic [7:0] EXP_ALL_ONES  = 8'hFF;
  localparam logic [7:0] EXP_OVF_MIN   = 8'd143;
  localparam logic [7:0] EXP_NORM_MIN  = 8'd113;
  localparam logic [7:0] EXP_DENRM_MIN = 8'd101;

endpackage

// File: rtl/f2h_rst_sync.sv
module f2h_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/f2h_lane.sv
module f2h_lane
  import f2h_pkg::*;
(
  input  logic [SP_W-1:0] sp_i,
  output logic [HP_W-1:0] hp_o
);

  logic        sgn;
  logic [7:0]  ex;
  logic [22:0] mf;

  assign sgn = sp_i[31];
  assign ex  = sp_i[30:23];
  assign mf  = sp_i[22:0];

  // normal-result path: rebias exponent, round mantissa at bit 12
  logic [4:0]  n_exp;
  logic [14:0] n_base;
  logic        n_rnd;
  logic [14:0] n_mag;

  always_comb begin
    n_exp  = ex[4:0] + 5'd16;
    n_base = {n_exp, mf[22:13]};
    n_rnd  = mf[12] & ((|mf[11:0]) | mf[13]);
    n_mag  = n_base + {14'd0, n_rnd};
  end

  // denormal-result path: align hidden-one significand, round at guard
  logic [3:0]  d_sh;
  logic [34:0] d_vec;
  logic [9:0]  d_man;
  logic        d_grd;
  logic        d_stk;
  logic        d_rnd;
  logic [14:0] d_mag;

  always_comb begin
    d_sh  = 4'd0 - ex[3:0];
    d_vec = {1'b1, mf, 11'd0} >> d_sh;
    d_man = d_vec[34:25];
    d_grd = d_vec[24];
    d_stk = |d_vec[23:0];
    d_rnd = d_grd & (d_stk | d_man[0]);
    d_mag = {5'd0, d_man} + {14'd0, d_rnd};
  end

  // class selection
  logic [14:0] mag;

  always_comb begin
    if (ex == EXP_ALL_ONES) begin
      mag = (mf != 23'd0) ? HP_QNAN_MAG : HP_INF_MAG;
    end else if (ex >= EXP_OVF_MIN) begin
      mag = HP_INF_MAG;
    end else if (ex >= EXP_NORM_MIN) begin
      mag = n_mag;
    end else if (ex >= EXP_DENRM_MIN) begin
      mag = d_mag;
    end else begin
      mag = 15'd0;
    end
  end

  assign hp_o = {sgn, mag};

endmodule

// File: rtl/f2h_pack.sv
module f2h_pack
  import f2h_pkg::*;
#(
  parameter int NUM_ELEM = 4
) (
  input  logic [NUM_ELEM*SP_W-1:0]   elems_i,
  input  vsize_e                     size_i,
  output logic [NUM_ELEM*HP_W-1:0]   words_o,
  output vsize_e                     osize_o,
  output logic                       legal_o
);

  localparam int NUM_WORDS = NUM_ELEM / 2;
  localparam int WORD_W    = 2 * HP_W;

  logic [HP_W-1:0] half [NUM_ELEM];
  logic [1:0]      n_words;

  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_lane
    f2h_lane u_lane (
      .sp_i (elems_i[e*SP_W +: SP_W]),
      .hp_o (half[e])
    );
  end

  always_comb begin
    unique case (size_i)
      VSZ_PAIR: n_words = 2'd1;
      VSZ_QUAD: n_words = 2'd2;
      default:  n_words = 2'd0;
    endcase
    legal_o = (size_i == VSZ_PAIR) || (size_i == VSZ_QUAD);
    osize_o = (size_i == VSZ_QUAD) ? VSZ_PAIR : VSZ_SINGLE;
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign words_o[w*WORD_W +: WORD_W] =
      (n_words > 2'(w)) ? {half[2*w+1], half[2*w]} : '0;
  end

endmodule

// File: rtl/vec_f2h_pack.sv
module vec_f2h_pack
  import f2h_pkg::*;
#(
  parameter int NUM_ELEM   = 4,
  parameter int RST_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [1:0]               in_size,
  input  logic [NUM_ELEM*SP_W-1:0] in_data,
  output logic                     out_valid,
  output logic                     out_illegal,
  output logic [1:0]               out_size,
  output logic [NUM_ELEM*HP_W-1:0] out_data
);

  localparam int OUT_W = NUM_ELEM * HP_W;

  logic             rst_sync_n;
  logic [OUT_W-1:0] words;
  vsize_e           osize;
  logic             legal;

  f2h_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  f2h_pack #(.NUM_ELEM(NUM_ELEM)) u_pack (
    .elems_i (in_data),
    .size_i  (vsize_e'(in_size)),
    .words_o (words),
    .osize_o (osize),
    .legal_o (legal)
  );

  logic             valid_d, valid_q;
  logic             illegal_d, illegal_q;
  logic             load_en;
  logic [OUT_W-1:0] data_q;
  logic [1:0]       size_q;

  always_comb begin
    load_en   = in_valid & legal;
    valid_d   = in_valid & legal;
    illegal_d = in_valid & ~legal;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      valid_q   <= valid_d;
      illegal_q <= illegal_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      data_q <= words;
      size_q <= osize;
    end
  end

  assign out_valid   = valid_q;
  assign out_illegal = illegal_q;
  assign out_size    = size_q;
  assign out_data    = data_q;

endmodule

// File: rtl/f2h_checker.sv
module f2h_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [1:0]   in_size,
  input logic [127:0] in_data,
  input logic         out_valid,
  input logic         out_illegal,
  input logic [1:0]   out_size,
  input logic [63:0]  out_data
);

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid && in_size[0]));

  p_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal == $past(in_valid && !in_size[0]));

  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_illegal));

  p_osize_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_size == (($past(in_size) == 2'd3) ? 2'd1 : 2'd0));

  p_word1_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_size == 2'd0) |-> out_data[63:32] == 32'd0);

  p_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[15] == $past(in_data[31]) &&
                   out_data[31] == $past(in_data[63])));

  p_special_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_data[30:23] == 8'hFF)) |->
      out_data[14:0] == ($past(in_data[22:0] != 23'd0) ? 15'h7E00 : 15'h7C00));

  p_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_data[30:23] >= 8'd143 && in_data[30:23] != 8'hFF)) |->
      out_data[14:0] == 15'h7C00);

  p_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_data[30:23] < 8'd101)) |-> out_data[14:0] == 15'd0);

endmodule

bind vec_f2h_pack f2h_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_size     (in_size),
  .in_data     (in_data),
  .out_valid   (out_valid),
  .out_illegal (out_illegal),
  .out_size    (out_size),
  .out_data    (out_data)
);

// File: tb/tb_vec_f2h_pack.sv
`timescale 1ns/1ps
module tb_vec_f2h_pack;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   in_size;
  logic [127:0] in_data;
  logic         out_valid;
  logic         out_illegal;
  logic [1:0]   out_size;
  logic [63:0]  out_data;

  int checks = 0;
  int errors = 0;

  vec_f2h_pack dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_size     (in_size),
    .in_data     (in_data),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_size    (out_size),
    .out_data    (out_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {requirement number, single input, expected half}
  localparam int NV = 28;
  localparam logic [51:0] VEC [NV] = '{
    {4'd4, 32'h3F800000, 16'h3C00},  // R4 1.0
    {4'd1, 32'hC0000000, 16'hC000},  // R1 -2.0
    {4'd4, 32'h477FE000, 16'h7BFF},  // R4 largest finite half
    {4'd4, 32'h477FEFFF, 16'h7BFF},  // R4 just below tie
    {4'd4, 32'h477FF000, 16'h7C00},  // R4 tie carries to infinity
    {4'd4, 32'h3F801000, 16'h3C00},  // R4 tie to even, down
    {4'd4, 32'h3F803000, 16'h3C02},  // R4 tie to even, up
    {4'd4, 32'h3F801001, 16'h3C01},  // R4 above tie
    {4'd4, 32'h38800000, 16'h0400},  // R4 smallest normal
    {4'd4, 32'h41200000, 16'h4900},  // R4 10.0
    {4'd1, 32'h80000000, 16'h8000},  // R1 -0
    {4'd1, 32'h00000000, 16'h0000},  // R1 +0
    {4'd2, 32'h7F800000, 16'h7C00},  // R2 +inf
    {4'd2, 32'hFF800000, 16'hFC00},  // R2 -inf
    {4'd2, 32'h7FC00001, 16'h7E00},  // R2 NaN
    {4'd2, 32'hFF812345, 16'hFE00},  // R2 -NaN payload dropped
    {4'd3, 32'h47800000, 16'h7C00},  // R3 65536
    {4'd3, 32'h501502F9, 16'h7C00},  // R3 1e10
    {4'd3, 32'hD0000000, 16'hFC00},  // R3 negative overflow
    {4'd5, 32'h33800000, 16'h0001},  // R5 smallest denormal
    {4'd5, 32'h33000000, 16'h0000},  // R5 half of smallest, tie to 0
    {4'd5, 32'h33000001, 16'h0001},  // R5 just above half
    {4'd5, 32'h33C00000, 16'h0002},  // R5 1.5 units tie up
    {4'd5, 32'h34200000, 16'h0002},  // R5 2.5 units tie down
    {4'd5, 32'h387FC000, 16'h03FF},  // R5 largest denormal
    {4'd5, 32'h387FF000, 16'h0400},  // R5 rounds into normal
    {4'd5, 32'h00000001, 16'h0000},  // R5 input denormal flush
    {4'd5, 32'h80400000, 16'h8000}   // R5 negative denormal flush
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] sz, input logic [127:0] d);
    @(negedge clk);
    in_size  = sz;
    in_data  = d;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n    = 1'b1;
    in_valid = 1'b0;
    in_size  = 2'd0;
    in_data  = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset valid", {63'd0, out_valid}, 64'd0);
    chk("R10 reset illegal", {63'd0, out_illegal}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk, four elements per quad vector (R7 packing)
    for (int i = 0; i < NV; i += 4) begin
      send(2'd3, {VEC[i+3][47:16], VEC[i+2][47:16], VEC[i+1][47:16], VEC[i][47:16]});
      chk("R7 quad valid", {63'd0, out_valid}, 64'd1);
      chk("R7 quad size", {62'd0, out_size}, 64'd1);
      for (int k = 0; k < 4; k++) begin
        string tg;
        tg = $sformatf("R%0d elem %0d input %h", VEC[i+k][51:48], i+k, VEC[i+k][47:16]);
        chk(tg, {48'd0, out_data[16*k +: 16]}, {48'd0, VEC[i+k][15:0]});
      end
    end

    // R9: idle cycle after a result
    @(negedge clk);
    chk("R9 idle valid", {63'd0, out_valid}, 64'd0);
    chk("R9 idle illegal", {63'd0, out_illegal}, 64'd0);

    // R6: pair packing, upper elements ignored, word1 zero, size single
    send(2'd1, {32'h7F800000, 32'h47800000, 32'hC0000000, 32'h3F800000});
    chk("R6 pair valid", {63'd0, out_valid}, 64'd1);
    chk("R6 pair size", {62'd0, out_size}, 64'd0);
    chk("R6 pair data", out_data, 64'h00000000_C0003C00);

    // R8: single and triple sizes are rejected
    send(2'd0, {96'd0, 32'h3F800000});
    chk("R8 single illegal", {63'd0, out_illegal}, 64'd1);
    chk("R8 single no valid", {63'd0, out_valid}, 64'd0);
    send(2'd2, {32'd0, 32'h3F800000, 32'h3F800000, 32'h3F800000});
    chk("R8 triple illegal", {63'd0, out_illegal}, 64'd1);
    chk("R8 triple no valid", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    chk("R9 illegal one cycle", {63'd0, out_illegal}, 64'd0);

    // R10: asynchronous clear in mid-run
    @(negedge clk);
    in_size  = 2'd3;
    in_data  = {4{32'h3F800000}};
    in_valid = 1'b1;
    @(negedge clk);
    chk("R10 pre-reset valid", {63'd0, out_valid}, 64'd1);
    in_valid = 1'b0;
    rst_n    = 1'b0;
    #1;
    chk("R10 async clear", {63'd0, out_valid}, 64'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 after release", {63'd0, out_valid}, 64'd0);

    // R1/R7: mixed-sign quad after reset
    send(2'd3, {32'hFF800000, 32'h00000000, 32'h80000000, 32'hBF800000});
    chk("R1 R7 mixed quad", out_data, 64'hFC00_0000_8000_BC00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule